// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether a received Ethernet frame is kept or dropped, based on its 48-bit destination address. An upstream receiver hands it a byte stream, with a strobe and the position of each byte in the frame. It also supplies the broadcast and multicast flags it has already decoded, plus a 6-bit hash index taken from the running CRC, along with a strobe for that index. Register inputs provide the station address, a 64-bit multicast hash table and the mode controls.

The destination address occupies byte positions 2 to 7. The verdict is issued once, in the cycle after the strobe for position 7. A frame that no rule accepts produces a single-cycle `abort_o` pulse. When promiscuous mode is on, no frame is aborted. Instead, `addr_miss_o` records that the frame was kept only because of that mode. That flag holds until the next verdict, so a descriptor writer can pick it up after the end of the frame.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: Unicast match. The byte at position 2 is compared with station address bits [47:40], and so on, until position 7 is compared with bits [7:0]. The frame is accepted when all six bytes are equal.
- R2: Broadcast. When `bcast_i` is 1 and `bcast_dis_i` is 0, the frame is accepted. When `bcast_dis_i` is 1, a broadcast frame is rejected, and a hash hit does not accept it either.
- R3: Multicast hash. A frame is accepted when `mcast_i` is 1, `bcast_i` is 0 and the table bit selected by the index captured on `hash_stb_i` is 1. Indexes 0..31 select bit idx of `hash_lo_i`, and indexes 32..63 select bit idx-32 of `hash_hi_i`. When `mcast_i` is 0, the hash table is not consulted.
- R4: When both `pass_all_i` and `ctrl_addr_ok_i` are 1, the frame is accepted. Either of them alone accepts nothing.
- R5: When `promisc_i` is 1, no abort is issued. `addr_miss_o` becomes 1 exactly when none of R1 to R4 accepts the frame, and 0 otherwise.
- R6: `abort_o` is a one-cycle pulse. It is high in the cycle after the position-7 strobe of a rejected frame, and low at all other times.
- R7: `addr_miss_o` changes only at a verdict. Its value holds through the end-of-frame pulse and the idle cycles that follow.
- R8: Reset (`rst_ni` low) forces `abort_o` and `addr_miss_o` to 0.
- R9: `end_frm_i` clears the captured hash result and the unicast match state. A later multicast frame that has no hash strobe is therefore rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_stb_i | input | 1 | A frame byte is present this cycle |
| byte_pos_i | input | 16 | Position of the byte in the frame |
| byte_i | input | 8 | Frame byte |
| end_frm_i | input | 1 | End-of-frame or abort pulse that clears per-frame state |
| bcast_i | input | 1 | Destination decoded as all-ones |
| mcast_i | input | 1 | Group bit of the first destination byte |
| hash_stb_i | input | 1 | Hash index is valid |
| hash_idx_i | input | 6 | CRC-derived hash index |
| station_i | input | 48 | Station address, first transmitted byte in [47:40] |
| hash_lo_i | input | 32 | Hash table bits 0..31 |
| hash_hi_i | input | 32 | Hash table bits 32..63 |
| bcast_dis_i | input | 1 | Reject broadcast frames |
| promisc_i | input | 1 | Keep every frame and flag misses |
| pass_all_i | input | 1 | Allow the control-frame path |
| ctrl_addr_ok_i | input | 1 | Control-frame address recognised upstream |
| abort_o | output | 1 | Reject pulse |
| addr_miss_o | output | 1 | Frame kept only by promiscuous mode |

## Verification
Frames are driven with the destination equal to the station address, with a mismatch only in the first byte, and with a mismatch only in the last byte. Together these show that all six positions are compared, and in the correct order. Broadcast and multicast frames are paired with hash indexes that hit in the lower word, hit at the top bit, miss, and land in the upper word on a bit that is set only in the lower word. This separates the two halves of the table and shows that a broadcast cannot enter through the hash. The pass-all cases set each of its two inputs alone and then both together, and the promiscuous cases repeat accepted and rejected frames to split the miss flag from the abort. Directed runs cover reset in the middle of operation and a multicast frame that follows a frame whose hash hit was cleared.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  typedef struct packed {
    logic uni;
    logic bc;
    logic mc;
    logic ctl;
  } hit_t;
endpackage

// File: rtl/uaf_ucast_cmp.sv
module uaf_ucast_cmp #(
  parameter int ADDR_BYTES = 6,
  parameter int FIRST_POS  = 2,
  parameter int POS_W      = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    byte_stb_i,
  input  logic [POS_W-1:0]        byte_pos_i,
  input  logic [7:0]              byte_i,
  input  logic [8*ADDR_BYTES-1:0] station_i,
  output logic                    match_o
);
  logic [ADDR_BYTES-1:0] at_vec, eq_vec;
  logic cur_eq, in_addr, match_q;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
    assign at_vec[k] = (byte_pos_i == POS_W'(FIRST_POS + k));
    assign eq_vec[k] = at_vec[k] && (byte_i == station_i[8*(ADDR_BYTES-k)-1 -: 8]);
  end

  assign cur_eq  = |eq_vec;
  assign in_addr = |at_vec;
  // running match including the current byte
  assign match_o = (at_vec[0] ? 1'b1 : match_q) & cur_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   match_q <= 1'b0;
    else if (clr_i)                match_q <= 1'b0;
    else if (byte_stb_i && in_addr) match_q <= match_o;
  end

  AST_UCAST_FIRST_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && byte_pos_i == POS_W'(FIRST_POS) &&
     byte_i != station_i[8*ADDR_BYTES-1 -: 8]) |=> !match_q); // R1
endmodule

// File: rtl/uaf_hash_sel.sv
module uaf_hash_sel #(
  parameter int HASH_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    stb_i,
  input  logic [HASH_W-1:0]       idx_i,
  input  logic [(1<<HASH_W)/2-1:0] tbl_lo_i,
  input  logic [(1<<HASH_W)/2-1:0] tbl_hi_i,
  output logic                    hit_o
);
  localparam int TBL_BITS = 1 << HASH_W;
  logic [TBL_BITS-1:0] tbl;

  assign tbl = {tbl_hi_i, tbl_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hit_o <= 1'b0;
    else if (clr_i) hit_o <= 1'b0;
    else if (stb_i) hit_o <= tbl[idx_i];
  end

  AST_HASH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !clr_i && tbl == '0) |=> !hit_o); // R3
endmodule

// File: rtl/uaf_decide.sv
module uaf_decide
  import uaf_pkg::*;
(
  input  hit_t hit_i,
  input  logic promisc_i,
  output logic reject_o,
  output logic miss_o
);
  logic any_hit;
  assign any_hit  = |hit_i;
  assign reject_o = !any_hit && !promisc_i;
  assign miss_o   = !any_hit && promisc_i;
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import uaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int FIRST_POS  = 2,
  parameter int POS_W      = 16,
  parameter int HASH_W     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_stb_i,
  input  logic [POS_W-1:0]        byte_pos_i,
  input  logic [7:0]              byte_i,
  input  logic                    end_frm_i,
  input  logic                    bcast_i,
  input  logic                    mcast_i,
  input  logic                    hash_stb_i,
  input  logic [HASH_W-1:0]       hash_idx_i,
  input  logic [8*ADDR_BYTES-1:0] station_i,
  input  logic [(1<<HASH_W)/2-1:0] hash_lo_i,
  input  logic [(1<<HASH_W)/2-1:0] hash_hi_i,
  input  logic                    bcast_dis_i,
  input  logic                    promisc_i,
  input  logic                    pass_all_i,
  input  logic                    ctrl_addr_ok_i,
  output logic                    abort_o,
  output logic                    addr_miss_o
);
  localparam int LAST_POS = FIRST_POS + ADDR_BYTES - 1;

  logic uni_match, hash_hit, last_stb, reject_d, miss_d;
  hit_t hits;

  assign last_stb = byte_stb_i && (byte_pos_i == POS_W'(LAST_POS));

  uaf_ucast_cmp #(.ADDR_BYTES(ADDR_BYTES), .FIRST_POS(FIRST_POS), .POS_W(POS_W)) u_ucast (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(end_frm_i), .byte_stb_i(byte_stb_i),
    .byte_pos_i(byte_pos_i), .byte_i(byte_i), .station_i(station_i), .match_o(uni_match)
  );

  uaf_hash_sel #(.HASH_W(HASH_W)) u_hash (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(end_frm_i), .stb_i(hash_stb_i),
    .idx_i(hash_idx_i), .tbl_lo_i(hash_lo_i), .tbl_hi_i(hash_hi_i), .hit_o(hash_hit)
  );

  // broadcast never enters through the hash path
  assign hits.uni = uni_match;
  assign hits.bc  = bcast_i && !bcast_dis_i;
  assign hits.mc  = mcast_i && !bcast_i && hash_hit;
  assign hits.ctl = pass_all_i && ctrl_addr_ok_i;

  uaf_decide u_decide (
    .hit_i(hits), .promisc_i(promisc_i), .reject_o(reject_d), .miss_o(miss_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o     <= 1'b0;
      addr_miss_o <= 1'b0;
    end else begin
      abort_o <= last_stb && reject_d;
      if (last_stb) addr_miss_o <= miss_d;
    end
  end

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R6
  AST_ABORT_AT_DECISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(last_stb)); // R6
  AST_PROMISC_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_stb && promisc_i) |=> !abort_o); // R5
  AST_ABORT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !addr_miss_o); // R5
endmodule

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;
  localparam logic [47:0] STATION = 48'h0A1B2C3D4E5F;
  localparam logic [31:0] TBL_LO  = 32'h0000_0010;  // bit 4
  localparam logic [31:0] TBL_HI  = 32'h8000_0000;  // bit 63

  typedef struct packed {
    logic [47:0] dest;
    logic bc, mc;
    logic [5:0] idx;
    logic bdis, pro, pa, cok;
    logic ab, ms;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{48'h0A1B2C3D4E5F, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 match
    '{48'h0A1B2C3D4E50, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 last byte
    '{48'hFA1B2C3D4E5F, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1}, // R1 first byte
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2}, // R2
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1, 6'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 no hash rescue
    '{48'h01005E000001, 1'b0, 1'b1, 6'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 lo hit
    '{48'h01005E000002, 1'b0, 1'b1, 6'd63, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 hi hit
    '{48'h01005E000003, 1'b0, 1'b1, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 miss
    '{48'h01005E000004, 1'b0, 1'b1, 6'd36, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 hi word
    '{48'h020000000000, 1'b0, 1'b0, 6'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 not mcast
    '{48'h020000000001, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4}, // R4
    '{48'h020000000001, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4}, // R4
    '{48'h020000000001, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4}, // R4
    '{48'h020000000001, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 miss
    '{48'h0A1B2C3D4E5F, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 match
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1, 6'd4,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5
    '{48'h01005E000005, 1'b0, 1'b1, 6'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_stb = 1'b0, end_frm = 1'b0, bcast = 1'b0, mcast = 1'b0, hash_stb = 1'b0;
  logic [15:0] byte_pos = '0;
  logic [7:0] byte_d = '0;
  logic [5:0] hash_idx = '0;
  logic bdis = 1'b0, pro = 1'b0, pa = 1'b0, cok = 1'b0;
  logic abort, miss;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  eth_rx_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_stb_i(byte_stb), .byte_pos_i(byte_pos), .byte_i(byte_d),
    .end_frm_i(end_frm), .bcast_i(bcast), .mcast_i(mcast), .hash_stb_i(hash_stb),
    .hash_idx_i(hash_idx), .station_i(STATION), .hash_lo_i(TBL_LO), .hash_hi_i(TBL_HI),
    .bcast_dis_i(bdis), .promisc_i(pro), .pass_all_i(pa), .ctrl_addr_ok_i(cok),
    .abort_o(abort), .addr_miss_o(miss)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drives positions 0..7; returns at the negedge after the position-7 edge
  task automatic send(input logic [47:0] dest, input logic bc, input logic mc,
                      input logic [5:0] idx, input logic do_hash);
    bcast = bc; mcast = mc; hash_idx = idx;
    for (int p = 0; p < 8; p++) begin
      byte_stb = 1'b1;
      byte_pos = 16'(p);
      byte_d   = (p < 2) ? 8'h55 : 8'(dest >> (8 * (7 - p)));
      hash_stb = do_hash && (p == 6);
      @(negedge clk);
    end
    byte_stb = 1'b0; hash_stb = 1'b0;
  endtask

  task automatic close_frame();
    end_frm = 1'b1; @(negedge clk);
    end_frm = 1'b0; bcast = 1'b0; mcast = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset abort", abort, 1'b0);
    check("R8 reset miss", miss, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bdis = VECS[i].bdis; pro = VECS[i].pro; pa = VECS[i].pa; cok = VECS[i].cok;
      send(VECS[i].dest, VECS[i].bc, VECS[i].mc, VECS[i].idx, 1'b1);
      check($sformatf("R%0d abort vec%0d", VECS[i].req, i), abort, VECS[i].ab);
      check($sformatf("R%0d miss vec%0d", VECS[i].req, i), miss, VECS[i].ms);
      @(negedge clk);
      check($sformatf("R6 pulse vec%0d", i), abort, 1'b0);
      close_frame();
      check($sformatf("R7 hold vec%0d", i), miss, VECS[i].ms);
    end

    // R9: cleared hash hit does not carry into a frame without a hash strobe
    bdis = 1'b0; pro = 1'b0; pa = 1'b0; cok = 1'b0;
    send(48'h01005E0000AA, 1'b0, 1'b1, 6'd4, 1'b1);
    check("R9 first accepted", abort, 1'b0);
    close_frame();
    send(48'h01005E0000AB, 1'b0, 1'b1, 6'd4, 1'b0);
    check("R9 stale hash cleared", abort, 1'b1);
    close_frame();

    // R7: miss stays through idle cycles; R8: reset clears it
    pro = 1'b1;
    send(48'h020000000009, 1'b0, 1'b0, 6'd0, 1'b1);
    check("R5 miss set", miss, 1'b1);
    close_frame();
    repeat (5) @(negedge clk);
    check("R7 idle hold", miss, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset miss", miss, 1'b0);
    check("R8 mid reset abort", abort, 1'b0);
    rst_n = 1'b1; pro = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule